// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Steering

This block turns an asynchronous serial line into characters. An external rate generator supplies `bit_tick`, a strobe that runs at `OVS` times the bit rate. The receiver confirms each start bit by sampling it again halfway through the bit. It then takes every later bit at its centre.

At run time the receiver can take 7 or 8 data bits, and it supports four parity treatments. Each finished character goes into a one-deep holding register. Parity, framing and overrun faults collect in a sticky three-bit status word. A routing bit decides where a faulty character signals: on the ordinary receive interrupt or on a dedicated error interrupt.

Software, or a register decoder outside the block, reads the character with `rd_data` and reads the fault flags with `rd_status`. Both strobes are one cycle wide. The receiver also needs two enables: the channel clock enable and the receive enable.

Top module: `uart_frame_rx`

## Requirements
- R1: A frame is one low start bit, then the data bits LSB first, then an optional parity bit, then a stop bit. With `len8`=1 there are 8 data bits. With `len8`=0 there are 7 data bits, and `rx_data[7]` reads 0.
- R2: `par_sel` chooses the parity treatment:
  - 00: no parity slot.
  - 01: a parity slot is present, but its value is never checked.
  - 10: odd parity.
  - 11: even parity.
  In odd and even mode, a mismatch sets `status[2]`.
- R3: A low level at the centre of the first stop bit sets `status[1]`. After such a frame, no new start bit is accepted until the line has been seen high.
- R4: A character can finish while the holding register is still full, with no `rd_data` strobe in that cycle. In that case `status[0]` is set, the new character is dropped, and `rx_data` keeps the old value. A `rd_data` strobe in the finishing cycle counts as a read, so the new character is stored.
- R5: A low level that is gone by the centre of the start bit is ignored. No character, flag or interrupt results from it.
- R6: `irq_rx` is a one-cycle pulse. It fires when a character is stored without error. It also fires for any faulty character when `err_to_rx`=1.
- R7: `irq_err` is a one-cycle pulse. It fires for a faulty character when `err_to_rx`=0, and in that case `irq_rx` stays low. The two pulses are never high together.
- R8: `rd_status` clears all three flags. A fault detected in the same cycle is still recorded.
- R9: With `rx_en`=0 nothing is received. With `clk_en`=0 nothing is received, and in addition the flags and the full state of the holding register are cleared.
- R10: After reset, `rx_data`, `status`, `irq_rx` and `irq_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Channel clock enable |
| rx_en | input | 1 | Receive enable |
| par_sel | input | 2 | Parity treatment |
| len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| err_to_rx | input | 1 | 1: faults signal on `irq_rx`, 0: faults signal on `irq_err` |
| bit_tick | input | 1 | Oversampling strobe (OVS per bit) |
| rxd | input | 1 | Serial line |
| rd_data | input | 1 | Character read strobe |
| rd_status | input | 1 | Status read strobe |
| rx_data | output | 8 | Holding register |
| status | output | 3 | {parity, framing, overrun} flags |
| irq_rx | output | 1 | Receive interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |

## Verification
Two pairs of events can land on the same clock edge: a read strobe and a finishing character.

The first pair is a status read and a new fault. The bench holds `rd_status` high for a whole frame that carries a bad parity bit. The parity flag must still be visible in the cycle of the interrupt pulse.

The second pair is a character read and a newly stored character. The bench holds `rd_data` high until the interrupt pulse appears. It then sends a further frame without reading, which must produce an overrun. The overrun proves that the character stored in the collision cycle left the holding register full.

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic       rx_en,
  input  logic [1:0] par_sel,
  input  logic       len8,
  input  logic       err_to_rx,
  input  logic       bit_tick,
  input  logic       rxd,
  input  logic       rd_data,
  input  logic       rd_status,
  output logic [7:0] rx_data,
  output logic [2:0] status,
  output logic       irq_rx,
  output logic       irq_err
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    bidx;
  logic [7:0]    shreg;
  logic          par_bit, full, line_hi, rx_m, rx_s;

  wire       slot_end = bit_tick && cnt == LAST;
  wire       done     = clk_en && rx_en && slot_end && st == S_STOP;
  wire [7:0] data_w   = len8 ? shreg : {1'b0, shreg[7:1]};
  wire       pe_w     = par_sel[1] & ~(^data_w ^ par_bit ^ par_sel[0]);
  wire       fe_w     = ~rx_s;
  wire       ovr_w    = full & ~rd_data;
  wire       err_w    = ovr_w | pe_w | fe_w;
  wire [2:0] stat_kept = rd_status ? 3'b000 : status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; shreg <= '0; par_bit <= 1'b0;
      full <= 1'b0; line_hi <= 1'b0; rx_data <= '0; status <= '0;
      irq_rx <= 1'b0; irq_err <= 1'b0;
    end else begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      if (rd_data)   full   <= 1'b0;
      if (rd_status) status <= 3'b000;
      if (!clk_en) begin
        st <= S_IDLE; full <= 1'b0; status <= 3'b000; line_hi <= 1'b0;
      end else if (!rx_en) begin
        st <= S_IDLE; line_hi <= 1'b0;
      end else if (bit_tick) begin
        case (st)
          S_IDLE: begin
            if (!rx_s && line_hi) begin
              st <= S_START; cnt <= '0; line_hi <= 1'b0;
            end else if (rx_s) begin
              line_hi <= 1'b1;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              bidx <= '0;
              if (rx_s) begin
                st <= S_IDLE; line_hi <= 1'b1;
              end else begin
                st <= S_DATA;
              end
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (slot_end) begin
              cnt   <= '0;
              shreg <= {rx_s, shreg[7:1]};
              if (bidx == (len8 ? 3'd7 : 3'd6))
                st <= (par_sel != 2'b00) ? S_PAR : S_STOP;
              else
                bidx <= bidx + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (slot_end) begin
              cnt <= '0; par_bit <= rx_s; st <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (slot_end) begin
              cnt <= '0;
              st <= S_IDLE;
              line_hi <= rx_s;
              if (ovr_w) begin
                status <= stat_kept | 3'b001;
              end else begin
                rx_data <= data_w;
                full    <= 1'b1;
                status  <= stat_kept | {pe_w, fe_w, 1'b0};
              end
              irq_rx  <= ~err_w | err_to_rx;
              irq_err <= err_w & ~err_to_rx;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(irq_rx && irq_err)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) irq_rx |=> !irq_rx); // R6
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (done && full && !rd_data) |=> ($stable(rx_data) && status[0])); // R4
  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_status && !done) |=> status == 3'b000); // R8
  AST_CLK_OFF: assert property (@(posedge clk) disable iff (!rst_n) !clk_en |=> (status == 3'b000 && !irq_rx && !irq_err)); // R9
endmodule

// File: tb/uart_frame_rx_test.sv
module uart_frame_rx_test;
  localparam int OVS = 16;
  localparam int BIT = 2 * OVS;

  logic clk = 0, rst_n = 0, clk_en = 1, rx_en = 1, len8 = 1, err_to_rx = 0;
  logic bit_tick = 0, rxd = 1, rd_data = 0, rd_status = 0;
  logic [1:0] par_sel = 2'b00;
  logic [7:0] rx_data;
  logic [2:0] status;
  logic irq_rx, irq_err;

  int checks = 0, fails = 0, ev_cnt = 0;
  logic [7:0] cap_data;
  logic [2:0] cap_stat;
  logic cap_rx, cap_err;

  uart_frame_rx #(.OVS(OVS)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .rx_en(rx_en), .par_sel(par_sel),
    .len8(len8), .err_to_rx(err_to_rx), .bit_tick(bit_tick), .rxd(rxd),
    .rd_data(rd_data), .rd_status(rd_status), .rx_data(rx_data), .status(status),
    .irq_rx(irq_rx), .irq_err(irq_err));

  always #5 clk = ~clk;
  always @(negedge clk) bit_tick <= ~bit_tick;

  always @(negedge clk)
    if (irq_rx || irq_err) begin
      ev_cnt++;
      cap_data = rx_data; cap_stat = status; cap_rx = irq_rx; cap_err = irq_err;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic v);
    @(negedge clk) rxd = v;
    repeat (BIT - 1) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] d, input logic l8);
    return l8 ? d : {1'b0, d[6:0]};
  endfunction

  function automatic logic exp_pe(input logic [1:0] ps, input logic bad);
    return ps[1] & bad;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic stop_v);
    logic p;
    drive_bit(1'b0);
    for (int i = 0; i < (len8 ? 8 : 7); i++) drive_bit(d[i]);
    if (par_sel != 2'b00) begin
      if (par_sel == 2'b01) p = 1'($urandom % 2);
      else p = (^exp_byte(d, len8)) ^ ~par_sel[0] ^ bad_par;
      drive_bit(p);
    end
    drive_bit(stop_v);
    @(negedge clk) rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic clear_all();
    @(negedge clk) begin rd_data = 1; rd_status = 1; end
    @(negedge clk) begin rd_data = 0; rd_status = 0; end
  endtask

  task automatic expect_event(input int ev0, input logic [7:0] ed, input logic [2:0] es, input string req);
    logic err;
    err = |es;
    chk(ev_cnt == ev0 + 1, {req, " event count"}, ev_cnt, ev0 + 1);
    chk(cap_data == ed, {req, " data"}, cap_data, ed);
    chk(cap_stat == es, {req, " status"}, cap_stat, es);
    chk(cap_rx == (!err || err_to_rx), "R6 irq_rx", cap_rx, !err || err_to_rx);
    chk(cap_err == (err && !err_to_rx), "R7 irq_err", cap_err, err && !err_to_rx);
  endtask

  task automatic frame_case(input logic [7:0] d, input logic bad, input logic stop_v, input string req);
    int ev0;
    ev0 = ev_cnt;
    send_frame(d, bad, stop_v);
    expect_event(ev0, exp_byte(d, len8), {exp_pe(par_sel, bad), ~stop_v, 1'b0}, req);
    clear_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int ev0;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    chk(rx_data == 8'h00 && status == 3'b000, "R10 reset regs", {rx_data, status}, 0);
    chk(!irq_rx && !irq_err, "R10 reset irqs", {irq_rx, irq_err}, 0);
    rst_n = 1;
    repeat (4 * BIT) @(negedge clk);

    frame_case(8'hA5, 0, 1, "R1 8bit");
    len8 = 0; par_sel = 2'b11;
    frame_case(8'hFF, 0, 1, "R1 7bit even");
    len8 = 1; par_sel = 2'b01;
    frame_case(8'h3C, 1, 1, "R2 zero parity unchecked");
    par_sel = 2'b10; err_to_rx = 0;
    frame_case(8'h81, 1, 1, "R2 odd bad R7");
    par_sel = 2'b11; err_to_rx = 1;
    frame_case(8'h5A, 1, 1, "R2 even bad R6");
    par_sel = 2'b00; err_to_rx = 0;
    frame_case(8'h96, 0, 0, "R3 framing");
    frame_case(8'h69, 0, 1, "R3 recovery");

    ev0 = ev_cnt;
    @(negedge clk) rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (3 * BIT) @(negedge clk);
    chk(ev_cnt == ev0 && status == 3'b000, "R5 glitch ignored", ev_cnt - ev0, 0);
    frame_case(8'hC3, 0, 1, "R5 after glitch");

    ev0 = ev_cnt;
    send_frame(8'h11, 0, 1);
    send_frame(8'h22, 0, 1);
    expect_event(ev0 + 1, 8'h11, 3'b001, "R4 overrun");
    clear_all();

    err_to_rx = 1; par_sel = 2'b10; ev0 = ev_cnt;
    rd_status = 1;
    send_frame(8'h07, 1, 1);
    rd_status = 0;
    expect_event(ev0, 8'h07, 3'b100, "R8 clear collides with error");
    @(negedge clk);
    chk(status == 3'b000, "R8 flags cleared", status, 0);
    clear_all();

    par_sel = 2'b00; err_to_rx = 0; ev0 = ev_cnt;
    rd_data = 1;
    fork
      send_frame(8'h44, 0, 1);
      begin
        do @(negedge clk); while (!(irq_rx || irq_err));
        rd_data = 0;
      end
    join
    send_frame(8'h55, 0, 1);
    expect_event(ev0 + 1, 8'h44, 3'b001, "R4 read in completion cycle");
    clear_all();

    rx_en = 0; ev0 = ev_cnt;
    send_frame(8'hEE, 0, 1);
    chk(ev_cnt == ev0 && status == 3'b000, "R9 rx disabled", ev_cnt - ev0, 0);
    rx_en = 1;
    repeat (BIT) @(negedge clk);

    send_frame(8'h12, 0, 0);
    @(negedge clk) clk_en = 0;
    repeat (4) @(negedge clk);
    chk(status == 3'b000, "R9 clock off clears flags", status, 0);
    clk_en = 1;
    repeat (BIT) @(negedge clk);
    frame_case(8'h34, 0, 1, "R9 buffer emptied");

    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      logic bad, stp;
      d = 8'($urandom);
      len8 = 1'($urandom % 2);
      par_sel = 2'($urandom % 4);
      err_to_rx = 1'($urandom % 2);
      bad = ($urandom % 4) == 0;
      stp = ($urandom % 6) != 0;
      frame_case(d, bad, stp, "R1 R2 R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule